// File: doc/BRIEF.md
# In-Order Commit Controller

This block decides, every clock cycle, which of the oldest in-flight instructions retire. It sees a window of the first `W` entries of the in-flight queue. Slot 0 is the head, the oldest entry. For each entry it sees the execution sequence number, the stream tag, the unit the entry was issued to, and these flags: memory reference, no-cost, barrier, and a requested extra commit delay. The entries retire strictly from slot 0 upward. The first slot that cannot retire ends the run for that cycle. A retiring entry either commits or, if its stream tag is stale, is discarded. Both kinds pop from the queue. When an entry leaves through a unit, the stall flag of that unit is released in the same cycle.

An entry is finished in one of three ways. Its unit shows a valid result carrying the entry's sequence number. A memory response for it arrives, if it is a memory reference. Or it is a no-cost entry, which needs neither. Commit can be held back by three things: a pending per-instruction delay; an incomplete barrier that is older than a memory reference; or a full store buffer while a barrier entry is at that point. Two per-cycle budgets apply, one for all instructions and one for memory references, and the run stops when either is used up. The register write-back datapath lies outside this block.

The parameters must satisfy `COMMIT_LIMIT >= 1` and `MEM_LIMIT <= COMMIT_LIMIT`.

Top module: `commit_ctrl`

## Requirements
- R1: The set of retired slots (commit_o | discard_o) is always a contiguous run starting at slot 0, and pop_cnt equals its size. A slot that is invalid or unfinished ends the run.
- R2: A slot that is not no-cost is finished only when one of two things holds. Either the unit it names (hd_unit, with index values 0 to NUM_FU-1 naming a unit) shows fu_out_valid with an equal sequence number. Or its memory flag is set and mem_resp_valid shows its sequence number.
- R3: A finished slot whose stream tag differs from cur_stream is flagged in discard_o, never in commit_o, and still pops. A discard uses no commit budget.
- R4: A raw delay value of 128 or more is ignored and treated as zero.
- R5: Take a head with an effective delay d of 1 to 127 that is first ready to commit in cycle t. It does not commit before cycle t+d, and it commits in cycle t+d if it is still ready then. A non-head slot with a nonzero effective delay ends the run for that cycle.
- R6: A memory-reference slot that is not finished by a memory response is held while bar_busy is set and bar_seq is numerically lower than its sequence number.
- R7: A barrier slot is held while sb_space is 0.
- R8: A no-cost slot commits without a unit result. It does not count against COMMIT_LIMIT and it sets no unstall bit.
- R9: The run stops once COMMIT_LIMIT non-no-cost commits (default 2) or MEM_LIMIT memory commits (default 1) have been made in the cycle.
- R10: unstall_o has bit u set exactly for unit u when a slot retired (commit or discard) through that unit's output in the same cycle.
- R11: Reset clears any pending delay, so a head that was waiting starts its delay again after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_valid | input | W | Slot holds an entry |
| hd_seq | input | W*SEQ_W | Execution sequence number per slot |
| hd_stream | input | W*ST_W | Stream tag per slot |
| hd_mem | input | W | Slot is a memory reference |
| hd_nocost | input | W | Slot is a no-cost instruction |
| hd_barrier | input | W | Slot is a memory barrier |
| hd_unit | input | W*FU_IDX_W | Unit index per slot |
| hd_delay | input | W*DLY_W | Requested extra commit delay per slot |
| cur_stream | input | ST_W | Current stream tag of the thread |
| fu_out_valid | input | NUM_FU | Unit output holds a result |
| fu_out_seq | input | NUM_FU*SEQ_W | Sequence number at each unit output |
| mem_resp_valid | input | 1 | A memory response is present |
| mem_resp_seq | input | SEQ_W | Sequence number of the memory response |
| bar_busy | input | 1 | An issued barrier has not completed |
| bar_seq | input | SEQ_W | Sequence number of that barrier |
| sb_space | input | 1 | Store buffer has a free entry |
| commit_o | output | W | Slot commits this cycle |
| discard_o | output | W | Slot is discarded this cycle |
| pop_cnt | output | POP_W | Entries popped this cycle |
| unstall_o | output | NUM_FU | Unit stall release |

## Verification
The delay counter is the state that is hardest to reach from the ports. Arming it needs a head that is otherwise fully ready, and the counter stays invisible until the one cycle in which the commit appears. The bench therefore holds a matching unit result steady for the whole window and checks every cycle of the wait for 3 and for 127 cycles. It also drops reset part way through a wait to show the count restarting. Everything that does not depend on the counter is covered by a sweep of several thousand pseudo-random window patterns against an arithmetic model. Those patterns mix stale tags, barriers, no-cost entries, memory responses and ignored large delays.

// File: rtl/commit_pkg.sv
package commit_pkg;

  // Delays at or above this bound are dropped.
  localparam int unsigned DELAY_CAP = 128;

  typedef struct packed {
    logic done;      // result available by some path
    logic stale;     // stream tag mismatch
    logic hold;      // barrier or store-buffer hold
    logic via_unit;  // finished through its unit output
    logic is_mem;
    logic no_cost;
  } slot_eval_t;

  function automatic int unsigned eff_delay(input int unsigned raw);
    return (raw < DELAY_CAP) ? raw : 0;
  endfunction

  function automatic logic is_older(input int unsigned a, input int unsigned b);
    return a < b;
  endfunction

endpackage

// File: rtl/commit_slot_eval.sv
module commit_slot_eval
  import commit_pkg::*;
#(
  parameter int NUM_FU   = 3,
  parameter int SEQ_W    = 8,
  parameter int ST_W     = 4,
  parameter int DLY_W    = 8,
  parameter int FU_IDX_W = 2
) (
  input  logic                    valid,
  input  logic [SEQ_W-1:0]        seq,
  input  logic [ST_W-1:0]         stream,
  input  logic                    mem,
  input  logic                    nocost,
  input  logic                    barrier,
  input  logic [FU_IDX_W-1:0]     unit,
  input  logic [DLY_W-1:0]        dly,
  input  logic [ST_W-1:0]         cur_stream,
  input  logic [NUM_FU-1:0]       fu_out_valid,
  input  logic [NUM_FU*SEQ_W-1:0] fu_out_seq,
  input  logic                    mem_resp_valid,
  input  logic [SEQ_W-1:0]        mem_resp_seq,
  input  logic                    bar_busy,
  input  logic [SEQ_W-1:0]        bar_seq,
  input  logic                    sb_space,
  output slot_eval_t              ev,
  output logic [DLY_W-1:0]        dly_eff
);

  logic unit_hit;
  logic resp_hit;

  always_comb begin
    unit_hit = 1'b0;
    for (int u = 0; u < NUM_FU; u++) begin
      if (unit == FU_IDX_W'(u) && fu_out_valid[u] &&
          fu_out_seq[u*SEQ_W +: SEQ_W] == seq)
        unit_hit = 1'b1;
    end
  end

  assign resp_hit = mem && mem_resp_valid && (mem_resp_seq == seq);

  always_comb begin
    ev.done     = valid && (nocost || unit_hit || resp_hit);
    ev.stale    = stream != cur_stream;
    ev.via_unit = !nocost && !resp_hit && unit_hit;
    ev.is_mem   = mem;
    ev.no_cost  = nocost;
    ev.hold     = (mem && !resp_hit && bar_busy &&
                   is_older(32'(bar_seq), 32'(seq))) ||
                  (barrier && !sb_space);
    dly_eff     = DLY_W'(eff_delay(32'(dly)));
  end

endmodule

// File: rtl/commit_delay_timer.sv
module commit_delay_timer #(
  parameter int SEQ_W = 8,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [DLY_W-1:0] arm_dly,
  input  logic [SEQ_W-1:0] head_seq,
  input  logic             head_retire,
  input  logic             head_commit,
  output logic             waiting,
  output logic             expired
);

  logic             armed;
  logic [SEQ_W-1:0] tag;
  logic [DLY_W-1:0] rem;
  logic             match;

  assign match   = armed && (tag == head_seq);
  assign waiting = match && (rem != '0);
  assign expired = match && (rem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      tag   <= '0;
      rem   <= '0;
    end else if (head_retire) begin
      armed <= 1'b0;
    end else if (arm) begin
      armed <= 1'b1;
      tag   <= head_seq;
      rem   <= arm_dly - DLY_W'(1);
    end else if (armed && rem != '0) begin
      rem <= rem - DLY_W'(1);
    end
  end

  // R5: a head with a running count never commits
  a_r5_hold_until_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !head_commit);

  // R5: arming never coincides with a head commit
  a_r5_arm_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> !head_commit);

endmodule

// File: rtl/commit_select.sv
module commit_select
  import commit_pkg::*;
#(
  parameter int W            = 4,
  parameter int NUM_FU       = 3,
  parameter int FU_IDX_W     = 2,
  parameter int DLY_W        = 8,
  parameter int COMMIT_LIMIT = 2,
  parameter int MEM_LIMIT    = 1
) (
  input  slot_eval_t [W-1:0]        ev,
  input  logic [W*DLY_W-1:0]        dly_eff,
  input  logic [W*FU_IDX_W-1:0]     unit,
  input  logic                      expired,
  input  logic                      waiting,
  output logic [W-1:0]              commit,
  output logic [W-1:0]              discard,
  output logic [NUM_FU-1:0]         unstall,
  output logic                      arm_req
);

  function automatic logic [NUM_FU-1:0] unit_bit(input logic [FU_IDX_W-1:0] idx);
    logic [NUM_FU-1:0] b;
    b = '0;
    for (int u = 0; u < NUM_FU; u++)
      if (idx == FU_IDX_W'(u)) b[u] = 1'b1;
    return b;
  endfunction

  always_comb begin
    int  n_all;
    int  n_mem;
    logic run;
    commit  = '0;
    discard = '0;
    unstall = '0;
    arm_req = 1'b0;
    n_all   = 0;
    n_mem   = 0;
    run     = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (run && ev[i].done && n_all < COMMIT_LIMIT && n_mem < MEM_LIMIT) begin
        if (ev[i].stale) begin
          discard[i] = 1'b1;
          if (ev[i].via_unit) unstall = unstall | unit_bit(unit[i*FU_IDX_W +: FU_IDX_W]);
        end else if (i == 0 && dly_eff[0 +: DLY_W] != '0 && !expired) begin
          arm_req = !waiting;
          run     = 1'b0;
        end else if (i != 0 && dly_eff[i*DLY_W +: DLY_W] != '0) begin
          run = 1'b0;
        end else if (ev[i].hold) begin
          run = 1'b0;
        end else begin
          commit[i] = 1'b1;
          if (!ev[i].no_cost) n_all = n_all + 1;
          if (ev[i].is_mem)   n_mem = n_mem + 1;
          if (ev[i].via_unit) unstall = unstall | unit_bit(unit[i*FU_IDX_W +: FU_IDX_W]);
        end
      end else begin
        run = 1'b0;
      end
    end
  end

endmodule

// File: rtl/commit_ctrl.sv
module commit_ctrl
  import commit_pkg::*;
#(
  parameter int W            = 4,
  parameter int NUM_FU       = 3,
  parameter int SEQ_W        = 8,
  parameter int ST_W         = 4,
  parameter int DLY_W        = 8,
  parameter int COMMIT_LIMIT = 2,
  parameter int MEM_LIMIT    = 1,
  localparam int FU_IDX_W    = (NUM_FU > 1) ? $clog2(NUM_FU + 1) : 1,
  localparam int POP_W       = $clog2(W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [W-1:0]            hd_valid,
  input  logic [W*SEQ_W-1:0]      hd_seq,
  input  logic [W*ST_W-1:0]       hd_stream,
  input  logic [W-1:0]            hd_mem,
  input  logic [W-1:0]            hd_nocost,
  input  logic [W-1:0]            hd_barrier,
  input  logic [W*FU_IDX_W-1:0]   hd_unit,
  input  logic [W*DLY_W-1:0]      hd_delay,
  input  logic [ST_W-1:0]         cur_stream,
  input  logic [NUM_FU-1:0]       fu_out_valid,
  input  logic [NUM_FU*SEQ_W-1:0] fu_out_seq,
  input  logic                    mem_resp_valid,
  input  logic [SEQ_W-1:0]        mem_resp_seq,
  input  logic                    bar_busy,
  input  logic [SEQ_W-1:0]        bar_seq,
  input  logic                    sb_space,
  output logic [W-1:0]            commit_o,
  output logic [W-1:0]            discard_o,
  output logic [POP_W-1:0]        pop_cnt,
  output logic [NUM_FU-1:0]       unstall_o
);

  slot_eval_t [W-1:0] slot_ev;
  logic [W*DLY_W-1:0] slot_dly;
  logic               tmr_waiting;
  logic               tmr_expired;
  logic               arm_req;
  logic [W-1:0]       retired;
  logic               head_retire;

  for (genvar i = 0; i < W; i++) begin : g_slot
    commit_slot_eval #(
      .NUM_FU(NUM_FU), .SEQ_W(SEQ_W), .ST_W(ST_W),
      .DLY_W(DLY_W), .FU_IDX_W(FU_IDX_W)
    ) u_eval (
      .valid         (hd_valid[i]),
      .seq           (hd_seq[i*SEQ_W +: SEQ_W]),
      .stream        (hd_stream[i*ST_W +: ST_W]),
      .mem           (hd_mem[i]),
      .nocost        (hd_nocost[i]),
      .barrier       (hd_barrier[i]),
      .unit          (hd_unit[i*FU_IDX_W +: FU_IDX_W]),
      .dly           (hd_delay[i*DLY_W +: DLY_W]),
      .cur_stream    (cur_stream),
      .fu_out_valid  (fu_out_valid),
      .fu_out_seq    (fu_out_seq),
      .mem_resp_valid(mem_resp_valid),
      .mem_resp_seq  (mem_resp_seq),
      .bar_busy      (bar_busy),
      .bar_seq       (bar_seq),
      .sb_space      (sb_space),
      .ev            (slot_ev[i]),
      .dly_eff       (slot_dly[i*DLY_W +: DLY_W])
    );
  end

  commit_select #(
    .W(W), .NUM_FU(NUM_FU), .FU_IDX_W(FU_IDX_W), .DLY_W(DLY_W),
    .COMMIT_LIMIT(COMMIT_LIMIT), .MEM_LIMIT(MEM_LIMIT)
  ) u_select (
    .ev     (slot_ev),
    .dly_eff(slot_dly),
    .unit   (hd_unit),
    .expired(tmr_expired),
    .waiting(tmr_waiting),
    .commit (commit_o),
    .discard(discard_o),
    .unstall(unstall_o),
    .arm_req(arm_req)
  );

  assign retired     = commit_o | discard_o;
  assign head_retire = retired[0];

  commit_delay_timer #(.SEQ_W(SEQ_W), .DLY_W(DLY_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm_req),
    .arm_dly    (slot_dly[0 +: DLY_W]),
    .head_seq   (hd_seq[0 +: SEQ_W]),
    .head_retire(head_retire),
    .head_commit(commit_o[0]),
    .waiting    (tmr_waiting),
    .expired    (tmr_expired)
  );

  always_comb begin
    pop_cnt = '0;
    for (int i = 0; i < W; i++) pop_cnt = pop_cnt + POP_W'(retired[i]);
  end

  // Independent view of the head's completion sources for the checks below.
  logic head_src;
  always_comb begin
    head_src = hd_nocost[0] ||
               (hd_mem[0] && mem_resp_valid && mem_resp_seq == hd_seq[0 +: SEQ_W]);
    for (int u = 0; u < NUM_FU; u++)
      if (hd_unit[0 +: FU_IDX_W] == FU_IDX_W'(u) && fu_out_valid[u] &&
          fu_out_seq[u*SEQ_W +: SEQ_W] == hd_seq[0 +: SEQ_W])
        head_src = 1'b1;
  end

  a_r1_contiguous_run: assert property (@(posedge clk) disable iff (!rst_n)
    ((retired + W'(1)) & retired) == '0);

  a_r2_head_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    head_retire |-> head_src);

  a_r3_stale_never_commits: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o[0] |-> hd_stream[0 +: ST_W] == cur_stream);

  a_r7_store_buffer_room: assert property (@(posedge clk) disable iff (!rst_n)
    (|(commit_o & hd_barrier)) |-> sb_space);

  a_r9_commit_budget: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(commit_o & ~hd_nocost) <= COMMIT_LIMIT);

  a_r9_mem_budget: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(commit_o & hd_mem) <= MEM_LIMIT);

  a_r10_unstall_needs_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (|unstall_o) |-> (|retired));

endmodule

// File: tb/commit_ctrl_bench.sv
module commit_ctrl_bench;

  localparam int W = 4, NF = 3, SW = 8, TW = 4, DW = 8, UW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0]    hd_valid, hd_mem, hd_nocost, hd_barrier;
  logic [W*SW-1:0] hd_seq;
  logic [W*TW-1:0] hd_stream;
  logic [W*UW-1:0] hd_unit;
  logic [W*DW-1:0] hd_delay;
  logic [TW-1:0]   cur_stream;
  logic [NF-1:0]   fu_out_valid;
  logic [NF*SW-1:0] fu_out_seq;
  logic            mem_resp_valid, bar_busy, sb_space;
  logic [SW-1:0]   mem_resp_seq, bar_seq;
  logic [W-1:0]    commit_o, discard_o;
  logic [2:0]      pop_cnt;
  logic [NF-1:0]   unstall_o;

  commit_ctrl #(.W(W), .NUM_FU(NF), .SEQ_W(SW), .ST_W(TW), .DLY_W(DW),
                .COMMIT_LIMIT(2), .MEM_LIMIT(1)) u_commit_ctrl (
    .clk(clk), .rst_n(rst_n), .hd_valid(hd_valid), .hd_seq(hd_seq),
    .hd_stream(hd_stream), .hd_mem(hd_mem), .hd_nocost(hd_nocost),
    .hd_barrier(hd_barrier), .hd_unit(hd_unit), .hd_delay(hd_delay),
    .cur_stream(cur_stream), .fu_out_valid(fu_out_valid), .fu_out_seq(fu_out_seq),
    .mem_resp_valid(mem_resp_valid), .mem_resp_seq(mem_resp_seq),
    .bar_busy(bar_busy), .bar_seq(bar_seq), .sb_space(sb_space),
    .commit_o(commit_o), .discard_o(discard_o), .pop_cnt(pop_cnt),
    .unstall_o(unstall_o));

  // Bench-side view of the stimulus
  logic          b_v[W], b_mem[W], b_nc[W], b_bar[W];
  logic [SW-1:0] b_seq[W];
  logic [TW-1:0] b_st[W];
  logic [UW-1:0] b_unit[W];
  logic [DW-1:0] b_dly[W];
  logic          b_ov[NF];
  logic [SW-1:0] b_os[NF];

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] rng = 32'h1badb002;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  task automatic rnd(output int unsigned r);
    rng = nxt(rng);
    r = rng;
  endtask

  task automatic pack();
    for (int i = 0; i < W; i++) begin
      hd_valid[i] = b_v[i]; hd_mem[i] = b_mem[i];
      hd_nocost[i] = b_nc[i]; hd_barrier[i] = b_bar[i];
      hd_seq[i*SW +: SW] = b_seq[i]; hd_stream[i*TW +: TW] = b_st[i];
      hd_unit[i*UW +: UW] = b_unit[i]; hd_delay[i*DW +: DW] = b_dly[i];
    end
    for (int u = 0; u < NF; u++) begin
      fu_out_valid[u] = b_ov[u]; fu_out_seq[u*SW +: SW] = b_os[u];
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < W; i++) begin
      b_v[i] = 0; b_mem[i] = 0; b_nc[i] = 0; b_bar[i] = 0;
      b_seq[i] = SW'(i); b_st[i] = '0; b_unit[i] = '0; b_dly[i] = '0;
    end
    for (int u = 0; u < NF; u++) begin b_ov[u] = 0; b_os[u] = '0; end
    cur_stream = '0; mem_resp_valid = 0; mem_resp_seq = '0;
    bar_busy = 0; bar_seq = '0; sb_space = 1;
  endtask

  task automatic slot(input int i, input logic [SW-1:0] s, input logic [UW-1:0] un,
                      input logic m, input logic nc, input logic br, input logic [DW-1:0] d);
    b_v[i] = 1; b_seq[i] = s; b_st[i] = cur_stream; b_unit[i] = un;
    b_mem[i] = m; b_nc[i] = nc; b_bar[i] = br; b_dly[i] = d;
  endtask

  function automatic int ones(input logic [W-1:0] m);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(m[i]);
    return n;
  endfunction

  task automatic check(input string req, input logic [W-1:0] ec, input logic [W-1:0] ed,
                       input logic [NF-1:0] eu);
    checks++;
    if (commit_o !== ec || discard_o !== ed || unstall_o !== eu ||
        int'(pop_cnt) != ones(ec | ed)) begin
      fails++;
      $display("FAIL %s: commit=%b discard=%b unstall=%b pop=%0d expected commit=%b discard=%b unstall=%b pop=%0d",
               req, commit_o, discard_o, unstall_o, pop_cnt, ec, ed, eu, ones(ec | ed));
    end
  endtask

  // Arithmetic model used for the sweep (no pending delay in play there)
  task automatic model(output logic [W-1:0] c, output logic [W-1:0] d, output logic [NF-1:0] u);
    int nc, nm, dl;
    bit go, uh, rh, fin, useu;
    c = '0; d = '0; u = '0; nc = 0; nm = 0; go = 1;
    for (int i = 0; i < W; i++) begin
      uh = 0;
      for (int k = 0; k < NF; k++)
        if (int'(b_unit[i]) == k && b_ov[k] && b_os[k] == b_seq[i]) uh = 1;
      rh   = b_mem[i] && mem_resp_valid && mem_resp_seq == b_seq[i];
      fin  = b_nc[i] || uh || rh;
      useu = !b_nc[i] && !rh && uh;
      dl   = b_dly[i][DW-1] ? 0 : int'(b_dly[i]);
      if (go) begin
        if (!(b_v[i] && fin) || nc >= 2 || nm >= 1) go = 0;
        else if (b_st[i] != cur_stream) begin
          d[i] = 1; if (useu) u = u | NF'(1 << b_unit[i]);
        end else if (dl != 0) go = 0;
        else if ((b_mem[i] && !rh && bar_busy && bar_seq < b_seq[i]) ||
                 (b_bar[i] && !sb_space)) go = 0;
        else begin
          c[i] = 1;
          if (!b_nc[i]) nc++;
          if (b_mem[i]) nm++;
          if (useu) u = u | NF'(1 << b_unit[i]);
        end
      end
    end
  endtask

  task automatic apply();
    @(negedge clk); pack(); #4;
  endtask

  task automatic step();
    @(negedge clk); #4;
  endtask

  initial begin
    #(1_500_000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ec, ed;
    logic [NF-1:0] eu;
    int unsigned r;
    logic [SW-1:0] base;
    clear_all(); pack();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: nothing valid, nothing retires
    apply(); check("R1 reset idle", '0, '0, '0);

    // R2: unit result must carry the head's sequence number
    clear_all(); slot(0, 8'd40, 2'd1, 0, 0, 0, 0); b_ov[1] = 1; b_os[1] = 8'd41;
    apply(); check("R2 wrong seq", '0, '0, '0);
    b_os[1] = 8'd40; apply(); check("R2 match", 4'b0001, '0, 3'b010);
    clear_all(); slot(0, 8'd40, 2'd3, 1, 0, 0, 0); mem_resp_valid = 1; mem_resp_seq = 8'd40;
    apply(); check("R2 mem response", 4'b0001, '0, '0);

    // R3: stale discards pop without budget use
    clear_all(); slot(0, 8'd50, 2'd0, 0, 0, 0, 0); slot(1, 8'd51, 2'd1, 0, 0, 0, 0);
    slot(2, 8'd52, 2'd2, 0, 0, 0, 0); b_st[0] = 4'hF;
    b_ov[0] = 1; b_os[0] = 8'd50; b_ov[1] = 1; b_os[1] = 8'd51; b_ov[2] = 1; b_os[2] = 8'd52;
    apply(); check("R3 discard", 4'b0110, 4'b0001, 3'b111);

    // R9: commit budget of 2
    b_st[0] = cur_stream; apply(); check("R9 commit limit", 4'b0011, '0, 3'b011);
    // R9: memory budget of 1
    clear_all(); slot(0, 8'd60, 2'd3, 1, 0, 0, 0); slot(1, 8'd61, 2'd0, 0, 0, 0, 0);
    mem_resp_valid = 1; mem_resp_seq = 8'd60; b_ov[0] = 1; b_os[0] = 8'd61;
    apply(); check("R9 mem limit", 4'b0001, '0, '0);

    // R8: no-cost entries commit without units and are not counted
    clear_all(); slot(0, 8'd70, 2'd3, 0, 1, 0, 0); slot(1, 8'd71, 2'd3, 0, 1, 0, 0);
    slot(2, 8'd72, 2'd2, 0, 0, 0, 0); slot(3, 8'd73, 2'd0, 0, 0, 0, 0);
    b_ov[2] = 1; b_os[2] = 8'd72; b_ov[0] = 1; b_os[0] = 8'd73;
    apply(); check("R8 no-cost", 4'b1111, '0, 3'b101);

    // R6: older incomplete barrier holds a memory reference
    clear_all(); slot(0, 8'd80, 2'd1, 1, 0, 0, 0); b_ov[1] = 1; b_os[1] = 8'd80;
    bar_busy = 1; bar_seq = 8'd79; apply(); check("R6 older barrier", '0, '0, '0);
    bar_seq = 8'd80; apply(); check("R6 same seq", 4'b0001, '0, 3'b010);
    bar_seq = 8'd79; bar_busy = 0; apply(); check("R6 barrier done", 4'b0001, '0, 3'b010);

    // R7: barrier waits for store buffer room
    clear_all(); slot(0, 8'd90, 2'd2, 0, 0, 1, 0); b_ov[2] = 1; b_os[2] = 8'd90;
    sb_space = 0; apply(); check("R7 full", '0, '0, '0);
    sb_space = 1; apply(); check("R7 room", 4'b0001, '0, 3'b100);

    // R4: large delay ignored
    clear_all(); slot(0, 8'd95, 2'd0, 0, 0, 0, 8'd200); b_ov[0] = 1; b_os[0] = 8'd95;
    apply(); check("R4 ignored delay", 4'b0001, '0, 3'b001);

    // Sweep of pseudo-random windows against the model
    for (int n = 0; n < 3000; n++) begin
      clear_all();
      rnd(r); base = SW'(r % 200);
      rnd(r); cur_stream = TW'(r % 16);
      for (int i = 0; i < W; i++) begin
        rnd(r);
        b_v[i] = (r % 8) != 0; b_seq[i] = base + SW'(i);
        b_st[i] = ((r >> 3) % 4 == 0) ? cur_stream ^ 4'h1 : cur_stream;
        b_mem[i] = ((r >> 6) % 3) == 0; b_nc[i] = ((r >> 9) % 6) == 0;
        b_bar[i] = ((r >> 12) % 7) == 0; b_unit[i] = UW'((r >> 15) % 4);
        b_dly[i] = ((r >> 18) % 5 == 0) ? DW'(128 + (r >> 21) % 128) : '0;
      end
      for (int u = 0; u < NF; u++) begin
        rnd(r); b_ov[u] = (r % 4) != 0; b_os[u] = base + SW'((r >> 2) % 5);
      end
      rnd(r);
      mem_resp_valid = r[0]; mem_resp_seq = base + SW'((r >> 1) % 4);
      bar_busy = r[4]; bar_seq = base + SW'((r >> 5) % 4) - SW'(1);
      sb_space = ((r >> 8) % 3) != 0;
      pack(); model(ec, ed, eu);
      @(negedge clk); #4;
      check("R1 R2 R3 R4 R6 R7 R8 R9 R10 sweep", ec, ed, eu);
    end

    // R5: delay 3 holds head, later slot with delay ends the run
    clear_all(); slot(0, 8'd20, 2'd1, 0, 0, 0, 8'd3); slot(1, 8'd21, 2'd0, 0, 0, 0, 8'd5);
    b_ov[1] = 1; b_os[1] = 8'd20; b_ov[0] = 1; b_os[0] = 8'd21;
    apply(); check("R5 wait 0", '0, '0, '0);
    for (int k = 1; k <= 3; k++) begin
      step();
      if (k < 3) check("R5 waiting", '0, '0, '0);
      else check("R5 expiry", 4'b0001, '0, 3'b010);
    end

    // R5: longest honoured delay 127
    clear_all(); slot(0, 8'd30, 2'd2, 0, 0, 0, 8'd127); b_ov[2] = 1; b_os[2] = 8'd30;
    apply(); check("R5 long wait 0", '0, '0, '0);
    for (int k = 1; k <= 127; k++) begin
      step();
      if (k < 127) check("R5 long waiting", '0, '0, '0);
      else check("R5 long expiry", 4'b0001, '0, 3'b100);
    end

    // R11: reset restarts a pending delay
    clear_all(); slot(0, 8'd35, 2'd0, 0, 0, 0, 8'd6); b_ov[0] = 1; b_os[0] = 8'd35;
    apply(); step(); step();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; #4;
    check("R11 restart", '0, '0, '0);
    for (int k = 1; k <= 6; k++) begin
      step();
      if (k < 6) check("R11 waiting", '0, '0, '0);
      else check("R11 expiry", 4'b0001, '0, 3'b001);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule